// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Controller

This block is the buffering and status core of one 16550-style serial channel. It holds a receive queue and a transmit queue, 16 entries each by default. It decodes the bus-side writes to the interrupt enable and FIFO control registers. From the queue state it builds the line status byte, the interrupt identification code and a single interrupt line. The receive shift register hands in characters, with per-character error flags, through a one-cycle valid strobe. The transmit shift register takes characters through a one-cycle pull strobe and reports through a busy level whether it is still shifting.

Software reads the receive head, the enable register, the identification code and the line status through a combinational read port. A read strobe on that port triggers the side effects of each register: it pops the receive queue, clears the transmit-empty condition, or clears the error flags. Two active-low ready outputs support a DMA engine in either single-transfer or block signalling.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the identification code reads 0x01, the line status reads 0x60 (with the shifter idle), and `irq`, `rxrdy_n` = 1 behaviour holds: `irq` is 0.
- R2: A write to address 2 stores bit 0 as queue enable, bit 3 as DMA block mode and bits 7:6 as trigger code. Bit 1 empties the receive queue and bit 2 empties the transmit queue, and neither bit is stored. A change of bit 0 empties both queues. The identification byte shows the enable bit in its bits 7:6.
- R3: Trigger codes 0, 1, 2 and 3 select receive levels 1, 4, 8 and 14. With enable register bit 0 set, the receive-data interrupt (identification 0x4) is asserted while the receive count is at or above the level and is deasserted once the count falls below it.
- R4: Line status bit 0 is 1 exactly while the receive queue holds a character. Characters leave through address-0 read strobes in arrival order.
- R5: A character that arrives while the receive queue is full is discarded and sets line status bit 1. That bit stays set until a line status read (address 5).
- R6: Receive error inputs bits 0, 1 and 2 (parity, framing, break) are stored with each character and appear as line status bits 2, 3 and 4 for the head entry. A line status read hides them for that head entry. Bit 7 stays 1 while any stored entry carries an error.
- R7: With enable bit 1 set, a transmit-empty interrupt (identification 0x2) is raised when a pull empties the transmit queue, or when bit 1 is newly enabled while the queue is empty. It is cleared by an identification read that reports it, or by any write to address 0.
- R8: With enable bits 3:0 all zero, `irq` stays 0 while line status still reports receive and transmit state.
- R9: Priority order is line error (identification 0x6, enable bit 2, any of line status bits 4:1), then receive data, then transmit empty. With nothing pending, the code is 0x1.
- R10: Line status bit 5 is 1 when the transmit queue is empty. Bit 6 is 1 when, in addition, `tx_busy` is 0.
- R11: A write to address 0 while the transmit queue is full is ignored. The transmitter receives characters in write order on `tx_data` while `tx_avail` is 1.
- R12: With queue enable 0, each queue holds one character: a second received character overruns, and a second transmit write is ignored.
- R13: In single mode, `rxrdy_n` is low while any character is held and `txrdy_n` is low while the transmit queue is empty. In block mode, `rxrdy_n` goes low at the trigger level and returns high only when the queue empties, and `txrdy_n` is low while a free transmit slot exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 data, 1 enable, 2 FIFO control) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; triggers read side effects |
| rd_addr | input | 3 | Read address (0 data, 1 enable, 2 identification, 5 line status) |
| rd_data | output | 8 | Combinational read data for rd_addr |
| rx_valid | input | 1 | Receive shifter delivers a character |
| rx_data | input | 8 | Received character |
| rx_err | input | 3 | Received errors: bit 0 parity, bit 1 framing, bit 2 break |
| tx_pull | input | 1 | Transmit shifter takes the head character |
| tx_busy | input | 1 | Transmit shifter still holds bits |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_data | output | 8 | Transmit queue head |
| isr | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |
| lsr | output | 8 | Line status byte |
| rxrdy_n | output | 1 | Receive DMA ready, active low |
| txrdy_n | output | 1 | Transmit DMA ready, active low |

## Verification
On every cycle the checker confirms the following properties. Receive-ready rises only after a delivered character. A character arriving at a full queue always flags an overrun. A write to the data address always drops the transmit-empty condition. Polled mode never raises `irq`. A pending line error always wins identification. Shift-idle implies an empty transmit queue. A write at full leaves the transmit count unchanged. The bench scenarios cover the facts that need a sequence to show. These are: the four trigger thresholds and the fall below them, data ordering and the identity of the discarded character, error flags following the head entry through pops and status reads, the priority hand-over as sources clear, and the hysteresis of the block-mode receive ready signal.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

   localparam logic [2:0] ADR_DATA = 3'd0;
   localparam logic [2:0] ADR_ENAB = 3'd1;
   localparam logic [2:0] ADR_CTRL = 3'd2;
   localparam logic [2:0] ADR_LINE = 3'd5;

   typedef enum logic [3:0] {
      ID_NONE    = 4'h1,
      ID_TXEMPTY = 4'h2,
      ID_RXDATA  = 4'h4,
      ID_LINE    = 4'h6
   } irq_id_e;

   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rx_err_t;

   typedef struct packed {
      logic [1:0] trig;
      logic       blk;
      logic       en;
   } qctl_t;

endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CW-1:0]    lim,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    cnt,
   output logic             full,
   output logic             empty
);

   if (DEPTH != (1 << AW)) begin : g_chk_pow2
      $error("ufc_fifo: DEPTH must be a power of two");
   end
   if (WIDTH < 1) begin : g_chk_width
      $error("ufc_fifo: WIDTH must be positive");
   end

   logic [AW-1:0]                wp, rp;
   logic                         do_push, do_pop;
   logic [DEPTH-1:0][WIDTH-1:0]  slots;

   assign full    = (cnt >= lim);
   assign empty   = (cnt == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      localparam logic [AW-1:0] IDX = AW'(g);
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk) begin
         if (do_push && (wp == IDX)) q <= din;
      end
      assign slots[g] = q;
   end

   assign dout = slots[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

endmodule

// File: rtl/ufc_regs.sv
module ufc_regs import ufc_pkg::*; #(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [7:0]    wr_data,
   input  logic          rd_en,
   input  logic [2:0]    rd_addr,
   output logic [3:0]    ier,
   output logic          q_en,
   output logic          q_blk,
   output logic [CW-1:0] trig_lvl,
   output logic [CW-1:0] q_lim,
   output logic          rx_clr,
   output logic          tx_clr,
   output logic          thr_wr,
   output logic          ier_wr,
   output logic          rhr_rd,
   output logic          isr_rd,
   output logic          lsr_rd
);

   if (DEPTH < 8) begin : g_chk_depth
      $error("ufc_regs: DEPTH below 8 leaves trigger levels ambiguous");
   end

   localparam logic [CW-1:0] LVL_0 = CW'(1);
   localparam logic [CW-1:0] LVL_1 = CW'(DEPTH / 4);
   localparam logic [CW-1:0] LVL_2 = CW'(DEPTH / 2);
   localparam logic [CW-1:0] LVL_3 = CW'(DEPTH - 2);

   qctl_t ctl_q;
   logic  ctl_wr, en_flip;

   assign thr_wr = wr_en && (wr_addr == ADR_DATA);
   assign ier_wr = wr_en && (wr_addr == ADR_ENAB);
   assign ctl_wr = wr_en && (wr_addr == ADR_CTRL);
   assign rhr_rd = rd_en && (rd_addr == ADR_DATA);
   assign isr_rd = rd_en && (rd_addr == ADR_CTRL);
   assign lsr_rd = rd_en && (rd_addr == ADR_LINE);

   assign en_flip = ctl_wr && (wr_data[0] != ctl_q.en);
   assign rx_clr  = ctl_wr && (wr_data[1] || en_flip);
   assign tx_clr  = ctl_wr && (wr_data[2] || en_flip);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier   <= '0;
         ctl_q <= '0;
      end else begin
         if (ier_wr) ier <= wr_data[3:0];
         if (ctl_wr) begin
            ctl_q.en   <= wr_data[0];
            ctl_q.blk  <= wr_data[3];
            ctl_q.trig <= wr_data[7:6];
         end
      end
   end

   assign q_en  = ctl_q.en;
   assign q_blk = ctl_q.blk & ctl_q.en;
   assign q_lim = ctl_q.en ? CW'(DEPTH) : CW'(1);

   always_comb begin
      if (!ctl_q.en) begin
         trig_lvl = LVL_0;
      end else begin
         unique case (ctl_q.trig)
            2'd0: trig_lvl = LVL_0;
            2'd1: trig_lvl = LVL_1;
            2'd2: trig_lvl = LVL_2;
            default: trig_lvl = LVL_3;
         endcase
      end
   end

endmodule

// File: rtl/ufc_irq.sv
module ufc_irq import ufc_pkg::*; #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    ier,
   input  logic          line_err,
   input  logic [CW-1:0] rx_cnt,
   input  logic [CW-1:0] trig_lvl,
   input  logic          tx_empty,
   input  logic          tx_drain,
   input  logic          ier_wr,
   input  logic          ier_tx_new,
   input  logic          thr_wr,
   input  logic          isr_rd,
   output irq_id_e       irq_id,
   output logic          irq,
   output logic          thre_pend
);

   logic line_act, data_act, tx_act;
   logic thre_set, thre_clr;

   assign thre_set = tx_drain || (ier_wr && ier_tx_new && !ier[1] && tx_empty);
   assign thre_clr = thr_wr || (isr_rd && (irq_id == ID_TXEMPTY));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        thre_pend <= 1'b0;
      else if (thre_set) thre_pend <= 1'b1;
      else if (thre_clr) thre_pend <= 1'b0;
   end

   assign line_act = ier[2] & line_err;
   assign data_act = ier[0] & (rx_cnt >= trig_lvl);
   assign tx_act   = ier[1] & thre_pend;

   always_comb begin
      if (line_act)      irq_id = ID_LINE;
      else if (data_act) irq_id = ID_RXDATA;
      else if (tx_act)   irq_id = ID_TXEMPTY;
      else               irq_id = ID_NONE;
   end

   assign irq = line_act | data_act | tx_act;

endmodule

// File: rtl/ufc_stat.sv
module ufc_stat import ufc_pkg::*; #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic          rx_full,
   input  logic          rx_push_ok,
   input  rx_err_t       rx_din_err,
   input  logic          rx_pop_ok,
   input  rx_err_t       rx_head_err,
   input  logic          rx_clr,
   input  logic [CW-1:0] rx_cnt,
   input  logic [CW-1:0] trig_lvl,
   input  logic          lsr_rd,
   input  logic          tx_empty,
   input  logic          tx_full,
   input  logic          tx_busy,
   input  logic          q_en,
   input  logic          q_blk,
   output logic [7:0]    lsr,
   output logic          rxrdy_n,
   output logic          txrdy_n
);

   logic          ovr_q, head_ack_q, blk_hold_q;
   logic [CW-1:0] bad_cnt;
   logic          rx_any, at_trig;
   logic          inc_bad, dec_bad;

   assign rx_any  = (rx_cnt != '0);
   assign at_trig = (rx_cnt >= trig_lvl);
   assign inc_bad = rx_push_ok && (|rx_din_err);
   assign dec_bad = rx_pop_ok && (|rx_head_err);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q      <= 1'b0;
         head_ack_q <= 1'b0;
         bad_cnt    <= '0;
         blk_hold_q <= 1'b0;
      end else begin
         if (rx_valid && rx_full) ovr_q <= 1'b1;
         else if (lsr_rd)         ovr_q <= 1'b0;

         if (rx_clr || rx_pop_ok)   head_ack_q <= 1'b0;
         else if (lsr_rd && rx_any) head_ack_q <= 1'b1;

         if (rx_clr) bad_cnt <= '0;
         else        bad_cnt <= bad_cnt + CW'(inc_bad) - CW'(dec_bad);

         if (at_trig)      blk_hold_q <= 1'b1;
         else if (!rx_any) blk_hold_q <= 1'b0;
      end
   end

   always_comb begin
      lsr[0]   = rx_any;
      lsr[1]   = ovr_q;
      lsr[4:2] = (rx_any && !head_ack_q) ? rx_head_err : 3'b000;
      lsr[5]   = tx_empty;
      lsr[6]   = tx_empty & ~tx_busy;
      lsr[7]   = q_en && (bad_cnt != '0);
   end

   always_comb begin
      if (q_blk) begin
         rxrdy_n = ~(at_trig | (blk_hold_q & rx_any));
         txrdy_n = tx_full;
      end else begin
         rxrdy_n = ~rx_any;
         txrdy_n = ~tx_empty;
      end
   end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl import ufc_pkg::*; #(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH) + 1,
   localparam int EW = $bits(rx_err_t),
   localparam int RW = 8 + EW
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   input  logic [2:0] rd_addr,
   output logic [7:0] rd_data,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   input  logic [2:0] rx_err,
   input  logic       tx_pull,
   input  logic       tx_busy,
   output logic       tx_avail,
   output logic [7:0] tx_data,
   output logic [7:0] isr,
   output logic       irq,
   output logic [7:0] lsr,
   output logic       rxrdy_n,
   output logic       txrdy_n
);

   logic [3:0]    ier;
   logic          q_en, q_blk;
   logic [CW-1:0] trig_lvl, q_lim;
   logic          rx_clr, tx_clr, thr_wr, ier_wr, rhr_rd, isr_rd, lsr_rd;

   logic [CW-1:0] rx_cnt, tx_cnt;
   logic          rx_full, rx_empty, tx_full, tx_empty;
   logic [RW-1:0] rx_head;
   rx_err_t       rx_head_err;
   logic          rx_push_ok, rx_pop_ok, tx_drain;
   logic          thre_pend;
   irq_id_e       irq_id;
   logic [CW-1:0] rx_lim, tx_lim;

   ufc_regs #(.DEPTH(DEPTH)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr),
      .ier(ier), .q_en(q_en), .q_blk(q_blk),
      .trig_lvl(trig_lvl), .q_lim(q_lim),
      .rx_clr(rx_clr), .tx_clr(tx_clr),
      .thr_wr(thr_wr), .ier_wr(ier_wr),
      .rhr_rd(rhr_rd), .isr_rd(isr_rd), .lsr_rd(lsr_rd)
   );

   assign rx_lim     = q_lim;
   assign tx_lim     = q_lim;
   assign rx_push_ok = rx_valid & ~rx_full;
   assign rx_pop_ok  = rhr_rd & ~rx_empty;
   assign tx_drain   = tx_pull && (tx_cnt == CW'(1)) && !thr_wr;

   ufc_fifo #(.WIDTH(RW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .lim(rx_lim),
      .push(rx_valid), .pop(rhr_rd),
      .din({rx_err, rx_data}), .dout(rx_head),
      .cnt(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   ufc_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr), .lim(tx_lim),
      .push(thr_wr), .pop(tx_pull),
      .din(wr_data), .dout(tx_data),
      .cnt(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   assign rx_head_err = rx_err_t'(rx_head[RW-1:8]);
   assign tx_avail    = ~tx_empty;

   ufc_stat #(.CW(CW)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_full(rx_full), .rx_push_ok(rx_push_ok),
      .rx_din_err(rx_err_t'(rx_err)), .rx_pop_ok(rx_pop_ok),
      .rx_head_err(rx_head_err), .rx_clr(rx_clr), .rx_cnt(rx_cnt),
      .trig_lvl(trig_lvl), .lsr_rd(lsr_rd),
      .tx_empty(tx_empty), .tx_full(tx_full), .tx_busy(tx_busy),
      .q_en(q_en), .q_blk(q_blk),
      .lsr(lsr), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
   );

   ufc_irq #(.CW(CW)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .ier(ier[2:0]), .line_err(|lsr[4:1]),
      .rx_cnt(rx_cnt), .trig_lvl(trig_lvl),
      .tx_empty(tx_empty), .tx_drain(tx_drain),
      .ier_wr(ier_wr), .ier_tx_new(wr_data[1]),
      .thr_wr(thr_wr), .isr_rd(isr_rd),
      .irq_id(irq_id), .irq(irq), .thre_pend(thre_pend)
   );

   assign isr = {q_en, q_en, 2'b00, irq_id};

   always_comb begin
      unique case (rd_addr)
         ADR_DATA: rd_data = rx_empty ? 8'h00 : rx_head[7:0];
         ADR_ENAB: rd_data = {4'h0, ier};
         ADR_CTRL: rd_data = isr;
         ADR_LINE: rd_data = lsr;
         default:  rd_data = 8'h00;
      endcase
   end

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk import ufc_pkg::*; #(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [2:0]    wr_addr,
   input logic          rx_valid,
   input logic          tx_pull,
   input logic          irq,
   input logic [7:0]    lsr,
   input logic [3:0]    ier,
   input logic [CW-1:0] rx_cnt,
   input logic [CW-1:0] rx_lim,
   input logic [CW-1:0] tx_cnt,
   input logic [CW-1:0] tx_lim,
   input logic          thre_pend,
   input logic [3:0]    irq_id
);

   // R4: data-ready can only appear after a delivered character
   a_r4_ready_from_rx: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lsr[0]) |-> $past(rx_valid));

   // R5: a character hitting a full queue always flags overrun
   a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && (rx_cnt >= rx_lim)) |=> lsr[1]);

   // R5: the receive count never passes the active limit
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= rx_lim);

   // R7: any data-address write drops the transmit-empty condition
   a_r7_thr_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADR_DATA)) |=> !thre_pend);

   // R8: polled mode keeps the interrupt line low
   a_r8_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ier == 4'h0) |-> !irq);

   // R9: an enabled line error always wins identification
   a_r9_line_first: assert property (@(posedge clk) disable iff (!rst_n)
      (ier[2] && (|lsr[4:1])) |-> (irq_id == ID_LINE));

   // R10: shift-idle implies the transmit queue is empty
   a_r10_idle_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
      lsr[6] |-> lsr[5]);

   // R11: a write at full leaves the transmit count unchanged
   a_r11_tx_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADR_DATA) && (tx_cnt >= tx_lim) && !tx_pull)
      |=> (tx_cnt == $past(tx_cnt)));

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .rx_valid(rx_valid), .tx_pull(tx_pull), .irq(irq), .lsr(lsr),
   .ier(ier), .rx_cnt(rx_cnt), .rx_lim(rx_lim),
   .tx_cnt(tx_cnt), .tx_lim(tx_lim),
   .thre_pend(thre_pend), .irq_id(irq_id)
);

// File: tb/sim_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module sim_uart_fifo_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic [2:0] rx_err = '0;
   logic       tx_pull = 1'b0;
   logic       tx_busy = 1'b0;
   logic       tx_avail;
   logic [7:0] tx_data;
   logic [7:0] isr;
   logic       irq;
   logic [7:0] lsr;
   logic       rxrdy_n, txrdy_n;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   uart_fifo_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
      .tx_pull(tx_pull), .tx_busy(tx_busy), .tx_avail(tx_avail),
      .tx_data(tx_data), .isr(isr), .irq(irq), .lsr(lsr),
      .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
   );

   // trigger code and expected receive level
   localparam logic [6:0] TRIG_TBL [4] = '{
      {2'd0, 5'd1}, {2'd1, 5'd4}, {2'd2, 5'd8}, {2'd3, 5'd14}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); rd_en = 1'b1; rd_addr = a; #1 d = rd_data;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      rd_addr = a; #1 d = rd_data;
   endtask

   task automatic rx_put(input logic [7:0] d, input logic [2:0] e);
      @(negedge clk); rx_valid = 1'b1; rx_data = d; rx_err = e;
      @(negedge clk); rx_valid = 1'b0; rx_err = '0;
   endtask

   task automatic tx_take(output logic [7:0] d);
      @(negedge clk); tx_pull = 1'b1; #1 d = tx_data;
      @(negedge clk); tx_pull = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] first;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R1 reset state
      peek(3'd5, v); check("R1 lsr", v, 8'h60);
      peek(3'd2, v); check("R1 isr", v, 8'h01);
      peek(3'd1, v); check("R1 ier", v, 8'h00);
      check("R1 irq", irq, 0);

      // R3 trigger table
      for (int t = 0; t < 4; t++) begin
         logic [1:0] code;
         int lvl;
         code = TRIG_TBL[t][6:5];
         lvl  = int'(TRIG_TBL[t][4:0]);
         bus_wr(3'd2, {code, 6'b000111});
         bus_wr(3'd1, 8'h01);
         for (int k = 0; k < lvl - 1; k++) rx_put(8'(k), 3'b000);
         #1 check("R3 below level", irq, 0);
         rx_put(8'hAA, 3'b000);
         #1 check("R3 at level", irq, 1);
         peek(3'd2, v); check("R3 isr code", v, 8'hC4);
         bus_rd(3'd0, v);
         #1 check("R3 below after read", irq, 0);
      end

      // R4 ordering and data-ready
      bus_wr(3'd1, 8'h00);
      bus_wr(3'd2, 8'h07);
      rx_put(8'hA1, 3'b000);
      rx_put(8'hB2, 3'b000);
      check("R4 ready set", lsr[0], 1);
      bus_rd(3'd0, v); check("R4 first out", v, 8'hA1);
      bus_rd(3'd0, v); check("R4 second out", v, 8'hB2);
      #1 check("R4 ready clear", lsr[0], 0);

      // R2 self-clearing bits
      rx_put(8'h11, 3'b000);
      bus_wr(3'd2, 8'h03);
      #1 check("R2 rx clear", lsr[0], 0);
      bus_wr(3'd0, 8'h55);
      bus_wr(3'd2, 8'h05);
      #1 check("R2 tx clear", lsr[5], 1);
      peek(3'd2, v); check("R2 enable mirror", v[7:6], 2'b11);

      // R5 overrun
      bus_wr(3'd2, 8'h07);
      for (int i = 0; i < 16; i++) rx_put(8'h10 + 8'(i), 3'b000);
      rx_put(8'hEE, 3'b000);
      #1 check("R5 overrun set", lsr[1], 1);
      bus_rd(3'd5, v); check("R5 overrun read", v[1], 1);
      #1 check("R5 overrun clear", lsr[1], 0);
      bus_rd(3'd0, first);
      for (int i = 1; i < 16; i++) bus_rd(3'd0, v);
      check("R5 oldest kept", first, 8'h10);
      check("R5 extra dropped", v, 8'h1F);
      #1 check("R5 drained", lsr[0], 0);

      // R6 error flags with head
      bus_wr(3'd2, 8'h07);
      bus_wr(3'd1, 8'h04);
      rx_put(8'h30, 3'b000);
      rx_put(8'h31, 3'b010);
      peek(3'd5, v); check("R6 clean head", v, 8'hE1);
      check("R6 no irq", irq, 0);
      bus_rd(3'd0, v); check("R6 data", v, 8'h30);
      peek(3'd5, v); check("R6 framing head", v, 8'hE9);
      peek(3'd2, v); check("R9 line code", v, 8'hC6);
      bus_rd(3'd5, v);
      peek(3'd5, v); check("R6 acked head", v, 8'hE1);
      check("R6 irq drop", irq, 0);
      rx_put(8'h32, 3'b101);
      bus_rd(3'd0, v);
      peek(3'd5, v); check("R6 break parity head", v, 8'hF5);
      bus_rd(3'd0, v);
      peek(3'd5, v); check("R6 no errored left", v, 8'h60);

      // R7 transmit-empty interrupt
      bus_wr(3'd1, 8'h02);
      peek(3'd2, v); check("R7 enable raise", v, 8'hC2);
      bus_rd(3'd2, v);
      #1 check("R7 isr read clears", irq, 0);
      bus_wr(3'd0, 8'h77);
      #1 check("R11 tx head", tx_data, 8'h77);
      check("R10 not empty", lsr[5], 0);
      tx_take(v); check("R11 tx pulled", v, 8'h77);
      #1 check("R7 drain raise", irq, 1);
      bus_wr(3'd0, 8'h78);
      #1 check("R7 write clears", irq, 0);
      tx_take(v);
      bus_rd(3'd2, v);

      // R9 priority hand-over
      bus_wr(3'd1, 8'h00);
      bus_wr(3'd1, 8'h07);
      peek(3'd2, v); check("R9 tx only", v, 8'hC2);
      rx_put(8'h40, 3'b000);
      peek(3'd2, v); check("R9 data over tx", v, 8'hC4);
      bus_rd(3'd0, v);
      rx_put(8'h41, 3'b001);
      peek(3'd2, v); check("R9 line over data", v, 8'hC6);
      bus_rd(3'd5, v);
      peek(3'd2, v); check("R9 back to data", v, 8'hC4);
      bus_rd(3'd0, v);
      peek(3'd2, v); check("R9 back to tx", v, 8'hC2);

      // R8 polled mode
      bus_wr(3'd1, 8'h00);
      rx_put(8'h50, 3'b001);
      #1 check("R8 irq quiet", irq, 0);
      check("R8 status live", lsr[2:0], 3'b101);
      bus_rd(3'd0, v);

      // R10 shifter idle flag
      @(negedge clk); tx_busy = 1'b1;
      #1 check("R10 busy", lsr[6:5], 2'b01);
      @(negedge clk); tx_busy = 1'b0;
      #1 check("R10 idle", lsr[6:5], 2'b11);
      bus_wr(3'd0, 8'h5A);
      #1 check("R10 loaded", lsr[6:5], 2'b00);
      bus_wr(3'd2, 8'h05);

      // R11 full transmit queue
      for (int i = 0; i < 16; i++) bus_wr(3'd0, 8'h80 + 8'(i));
      bus_wr(3'd0, 8'h99);
      tx_take(first);
      for (int i = 1; i < 16; i++) tx_take(v);
      check("R11 first", first, 8'h80);
      check("R11 extra ignored", v, 8'h8F);
      #1 check("R11 empty", tx_avail, 0);

      // R13 DMA ready signals
      bus_wr(3'd2, 8'h4F);
      check("R13 blk empty", rxrdy_n, 1);
      rx_put(8'h01, 3'b000);
      #1 check("R13 blk below", rxrdy_n, 1);
      check("R13 blk tx room", txrdy_n, 0);
      for (int i = 0; i < 3; i++) rx_put(8'h02, 3'b000);
      #1 check("R13 blk at trig", rxrdy_n, 0);
      for (int i = 0; i < 3; i++) bus_rd(3'd0, v);
      #1 check("R13 blk hold", rxrdy_n, 0);
      bus_rd(3'd0, v);
      #1 check("R13 blk released", rxrdy_n, 1);
      for (int i = 0; i < 16; i++) bus_wr(3'd0, 8'(i));
      #1 check("R13 blk tx full", txrdy_n, 1);
      bus_wr(3'd2, 8'h47);
      #1 check("R13 single tx empty", txrdy_n, 0);
      bus_wr(3'd0, 8'h33);
      #1 check("R13 single tx held", txrdy_n, 1);
      rx_put(8'h03, 3'b000);
      #1 check("R13 single rx", rxrdy_n, 0);

      // R12 queues disabled
      bus_wr(3'd2, 8'h00);
      bus_wr(3'd1, 8'h01);
      rx_put(8'h61, 3'b000);
      #1 check("R12 irq one char", irq, 1);
      peek(3'd2, v); check("R12 isr no fifo", v, 8'h04);
      rx_put(8'h62, 3'b000);
      #1 check("R12 overrun", lsr[1], 1);
      bus_rd(3'd0, v); check("R12 held char", v, 8'h61);
      #1 check("R12 rx empty", lsr[0], 0);
      bus_wr(3'd0, 8'h71);
      bus_wr(3'd0, 8'h72);
      tx_take(v); check("R12 tx one deep", v, 8'h71);
      #1 check("R12 tx empty", lsr[5], 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule